// File: doc/BRIEF.md
# Compensated Nanosecond Time Counter

This block keeps a 64-bit time value in nanoseconds. On every reference-clock edge while counting is enabled it adds an increment: normally a small default step, but on selected ticks a separate compensation step. Two trimming schemes choose those ticks. A burst count applies the compensation step on a fixed number of back-to-back ticks. A periodic reload value applies it on one tick out of every N. Software uses the two together to pull the counter's rate slightly faster or slower than the reference clock.

A word-wide register bus holds the configuration, the sticky overflow status, both trimming registers and the count. The count can be read and written as separate 32-bit halves. A read of the low half captures the high half at the same instant, so a high read that follows returns a matching value. A neighbouring compare unit can ask for the counter to restart from zero. The full count is also driven out on a port for that neighbour.

Top module: `ns_time_counter`

## Requirements
- R1: After reset the count is zero, the overflow flag is clear and every register reads zero.
- R2: The word addresses are 0 config, 1 status, 2 burst count, 3 periodic reload, 4 count low, 5 count high. Config bit 0 enables counting, bits 7:4 hold the default increment and bits 19:8 hold the compensation increment. Config reads back as written. While counting is enabled and no trimming applies, each clock adds the default increment.
- R3: While counting is disabled the count holds its value.
- R4: The burst count (address 2) is 24 bits wide. While it is nonzero, each enabled tick adds the compensation increment and the burst count drops by one. A read returns the number of ticks that remain.
- R5: A nonzero periodic reload value N (address 3) makes every Nth enabled tick add the compensation increment. The interval starts again from the tick after the write.
- R6: A periodic reload value of zero turns periodic compensation off.
- R7: A read of the low count word captures the high word at that clock edge. A later read of the high word returns the captured value.
- R8: A write to the low or high count word replaces only that half, and takes precedence over the increment on that edge.
- R9: A carry out of bit 63 sets status bit 0 and the overflow output, and they stay set. Writing 1 to status bit 0 clears them. Writing 0 has no effect.
- R10: A zero request loads zero on the next edge and takes precedence over the increment. A count-word write on the same edge takes precedence over the zero request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; each edge is one tick |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (captures the high word when the low word is read) |
| busAddr | input | 3 | Word address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for the current address, combinational |
| cntZeroReq | input | 1 | Request from the compare unit to restart the count at zero |
| timeNow | output | 64 | Current count |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
The hardest case to reach from the ports is a high-word read that is only coherent because of the capture: the high half must change between the low read and the high read. To get there, the stimulus parks the count a few ticks below a low-word wrap while the counter is disabled, enables it, reads the low word at once, and waits until the carry has moved into the high half before it reads that half. Overflow is reached the same way, by writing all ones into the high word while the counter is stopped. The trimming schemes are checked by the total growth over a fixed number of ticks, which does not depend on which exact edge a write lands on.

// File: rtl/ntc_pkg.sv
package ntc_pkg;
  localparam int WORD_W     = 32;
  localparam int CNT_W      = 2 * WORD_W;
  localparam int ADDR_W     = 3;
  localparam int DEF_INC_W  = 4;
  localparam int COMP_INC_W = 12;
  localparam int BURST_W    = 24;
  localparam int SLOW_W     = WORD_W;

  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_DEF_LSB  = 4;
  localparam int CFG_COMP_LSB = CFG_DEF_LSB + DEF_INC_W;

  localparam logic [ADDR_W-1:0] A_CFG    = 3'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
  localparam logic [ADDR_W-1:0] A_BURST  = 3'd2;
  localparam logic [ADDR_W-1:0] A_SLOW   = 3'd3;
  localparam logic [ADDR_W-1:0] A_LO     = 3'd4;
  localparam logic [ADDR_W-1:0] A_HI     = 3'd5;

  typedef struct packed {
    logic                  tick;
    logic [COMP_INC_W-1:0] incVal;
    logic                  loadZero;
    logic                  wrLo;
    logic                  wrHi;
    logic [WORD_W-1:0]     wrData;
    logic                  latchHi;
  } cmdT;
endpackage

// File: rtl/ntc_ctrl.sv
module ntc_ctrl
  import ntc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWrData,
  input  logic              cntZeroReq,
  input  logic              carryOut,
  input  logic [CNT_W-1:0]  cntNow,
  input  logic [WORD_W-1:0] hiLatched,
  output cmdT               cmd,
  output logic [WORD_W-1:0] busRdData,
  output logic              ovfFlag
);
  localparam int CFG_USED = CFG_COMP_LSB + COMP_INC_W;

  logic                  cntEn;
  logic [DEF_INC_W-1:0]  defInc;
  logic [COMP_INC_W-1:0] compInc;
  logic [BURST_W-1:0]    burstLeft;
  logic [SLOW_W-1:0]     slowReload;
  logic [SLOW_W-1:0]     slowLeft;
  logic                  ovfSticky;

  logic wrCfg, wrStatus, wrBurst, wrSlow;
  logic burstActive, slowExpire, useComp;

  assign wrCfg    = busWrEn && (busAddr == A_CFG);
  assign wrStatus = busWrEn && (busAddr == A_STATUS);
  assign wrBurst  = busWrEn && (busAddr == A_BURST);
  assign wrSlow   = busWrEn && (busAddr == A_SLOW);

  assign burstActive = (burstLeft != '0);
  assign slowExpire  = (slowReload != '0) && (slowLeft <= SLOW_W'(1));
  assign useComp     = burstActive || slowExpire;

  always_comb begin
    cmd.tick     = cntEn;
    cmd.incVal   = useComp ? compInc : COMP_INC_W'(defInc);
    cmd.loadZero = cntZeroReq;
    cmd.wrLo     = busWrEn && (busAddr == A_LO);
    cmd.wrHi     = busWrEn && (busAddr == A_HI);
    cmd.wrData   = busWrData;
    cmd.latchHi  = busRdEn && (busAddr == A_LO);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntEn      <= 1'b0;
      defInc     <= '0;
      compInc    <= '0;
      burstLeft  <= '0;
      slowReload <= '0;
      slowLeft   <= '0;
      ovfSticky  <= 1'b0;
    end else begin
      if (wrCfg) begin
        cntEn   <= busWrData[CFG_EN_BIT];
        defInc  <= busWrData[CFG_DEF_LSB +: DEF_INC_W];
        compInc <= busWrData[CFG_COMP_LSB +: COMP_INC_W];
      end
      if (wrBurst)
        burstLeft <= busWrData[BURST_W-1:0];
      else if (cntEn && burstActive)
        burstLeft <= burstLeft - BURST_W'(1);
      if (wrSlow) begin
        slowReload <= busWrData[SLOW_W-1:0];
        slowLeft   <= busWrData[SLOW_W-1:0];
      end else if (cntEn && (slowReload != '0)) begin
        slowLeft <= slowExpire ? slowReload : slowLeft - SLOW_W'(1);
      end
      if (carryOut)
        ovfSticky <= 1'b1;
      else if (wrStatus && busWrData[0])
        ovfSticky <= 1'b0;
    end
  end

  assign ovfFlag = ovfSticky;

  always_comb begin
    unique case (busAddr)
      A_CFG:    busRdData = {(WORD_W-CFG_USED)'(0), compInc, defInc,
                             (CFG_DEF_LSB-1)'(0), cntEn};
      A_STATUS: busRdData = {(WORD_W-1)'(0), ovfSticky};
      A_BURST:  busRdData = {(WORD_W-BURST_W)'(0), burstLeft};
      A_SLOW:   busRdData = slowReload;
      A_LO:     busRdData = cntNow[WORD_W-1:0];
      A_HI:     busRdData = hiLatched;
      default:  busRdData = '0;
    endcase
  end
endmodule

// File: rtl/ntc_datapath.sv
module ntc_datapath
  import ntc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cmdT               cmd,
  output logic [CNT_W-1:0]  cntNow,
  output logic [WORD_W-1:0] hiLatched,
  output logic              carryOut
);
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt;
  logic [WORD_W-1:0] hiCap;

  assign sum = {1'b0, cnt} + (CNT_W+1)'(cmd.incVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      hiCap <= '0;
    end else begin
      if (cmd.wrLo)
        cnt[WORD_W-1:0] <= cmd.wrData;
      else if (cmd.wrHi)
        cnt[CNT_W-1:WORD_W] <= cmd.wrData;
      else if (cmd.loadZero)
        cnt <= '0;
      else if (cmd.tick)
        cnt <= sum[CNT_W-1:0];
      if (cmd.latchHi)
        hiCap <= cnt[CNT_W-1:WORD_W];
    end
  end

  assign carryOut  = cmd.tick && !cmd.wrLo && !cmd.wrHi && !cmd.loadZero && sum[CNT_W];
  assign cntNow    = cnt;
  assign hiLatched = hiCap;
endmodule

// File: rtl/ns_time_counter.sv
module ns_time_counter
  import ntc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWrData,
  output logic [WORD_W-1:0] busRdData,
  input  logic              cntZeroReq,
  output logic [CNT_W-1:0]  timeNow,
  output logic              ovfFlag
);
  cmdT               cmd;
  logic              carryOut;
  logic [WORD_W-1:0] hiLatched;

  ntc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .cntZeroReq(cntZeroReq),
    .carryOut(carryOut), .cntNow(timeNow), .hiLatched(hiLatched),
    .cmd(cmd), .busRdData(busRdData), .ovfFlag(ovfFlag)
  );

  ntc_datapath dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cntNow(timeNow),
    .hiLatched(hiLatched), .carryOut(carryOut)
  );
endmodule

// File: rtl/ns_time_counter_chk.sv
module ns_time_counter_chk
  import ntc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [WORD_W-1:0] busWrData,
  input logic [WORD_W-1:0] busRdData,
  input logic              cntZeroReq,
  input logic [CNT_W-1:0]  timeNow,
  input logic              ovfFlag
);
  a_r10_zero_load: assert property (@(posedge clk) disable iff (!rstN)
    (cntZeroReq && !busWrEn) |=> (timeNow == '0));

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(busWrEn && busAddr == A_STATUS && busWrData[0])) |=> ovfFlag);

  a_r9_ovf_on_wrap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> (timeNow < $past(timeNow)));

  a_r7_hi_coherent: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busRdEn && busAddr == A_LO) && busRdEn && busAddr == A_HI)
      |-> (busRdData == $past(timeNow[CNT_W-1:WORD_W])));

  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (timeNow == '0 && !ovfFlag));
endmodule

bind ns_time_counter ns_time_counter_chk chk_i (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
  .cntZeroReq(cntZeroReq), .timeNow(timeNow), .ovfFlag(ovfFlag)
);

// File: tb/ns_time_counter_tb_top.sv
module ns_time_counter_tb_top;
  import ntc_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWrEn = 1'b0;
  logic              busRdEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [WORD_W-1:0] busWrData = '0;
  logic [WORD_W-1:0] busRdData;
  logic              cntZeroReq = 1'b0;
  logic [CNT_W-1:0]  timeNow;
  logic              ovfFlag;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  ns_time_counter dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .cntZeroReq(cntZeroReq), .timeNow(timeNow), .ovfFlag(ovfFlag)
  );

  localparam logic [31:0] CFG_RUN = 32'h0000_0751; // en=1, def=5, comp=7
  localparam logic [31:0] CFG_STOP = 32'h0000_0750;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(posedge clk); @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic ticks(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 count", timeNow, 64'd0);
    check("R1 ovf", {63'd0, ovfFlag}, 64'd0);
    rd(A_CFG, v);   check("R1 cfg", {32'd0, v}, 64'd0);
    rd(A_BURST, v); check("R1 burst", {32'd0, v}, 64'd0);
    rd(A_SLOW, v);  check("R1 slow", {32'd0, v}, 64'd0);
  endtask

  task automatic t_default();
    logic [31:0] v;
    logic [63:0] s0;
    wr(A_CFG, CFG_RUN);
    rd(A_CFG, v); check("R2 cfg readback", {32'd0, v}, {32'd0, CFG_RUN});
    s0 = timeNow;
    ticks(12);
    check("R2 default step", timeNow - s0, 64'd60);
  endtask

  task automatic t_disabled();
    logic [63:0] s0;
    wr(A_CFG, CFG_STOP);
    s0 = timeNow;
    ticks(10);
    check("R3 hold", timeNow, s0);
    wr(A_CFG, CFG_RUN);
  endtask

  task automatic t_burst();
    logic [31:0] v;
    logic [63:0] s0;
    wr(A_BURST, 32'd4);
    s0 = timeNow;
    ticks(10);
    check("R4 burst growth", timeNow - s0, 64'd58);
    rd(A_BURST, v); check("R4 burst drained", {32'd0, v}, 64'd0);
  endtask

  task automatic t_slow();
    logic [63:0] s0;
    wr(A_SLOW, 32'd3);
    s0 = timeNow;
    ticks(9);
    check("R5 periodic growth", timeNow - s0, 64'd51);
    wr(A_SLOW, 32'd0);
    s0 = timeNow;
    ticks(9);
    check("R6 periodic off", timeNow - s0, 64'd45);
  endtask

  task automatic t_latch();
    logic [31:0] v;
    wr(A_CFG, CFG_STOP);
    wr(A_HI, 32'd5);
    wr(A_LO, 32'hFFFF_FFF0);
    check("R8 word writes", timeNow, 64'h5_FFFF_FFF0);
    wr(A_CFG, CFG_RUN);
    rd(A_LO, v); check("R7 low read", {32'd0, v}, 64'hFFFF_FFF0);
    ticks(5);
    check("R7 high moved", {32'd0, timeNow[63:32]}, 64'd6);
    rd(A_HI, v); check("R7 captured high", {32'd0, v}, 64'd5);
    rd(A_LO, v);
    rd(A_HI, v); check("R7 recaptured high", {32'd0, v}, 64'd6);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    wr(A_CFG, CFG_STOP);
    wr(A_HI, 32'hFFFF_FFFF);
    wr(A_LO, 32'hFFFF_FFFE);
    check("R9 no ovf yet", {63'd0, ovfFlag}, 64'd0);
    wr(A_CFG, CFG_RUN);
    ticks(2);
    check("R9 ovf flag", {63'd0, ovfFlag}, 64'd1);
    rd(A_STATUS, v); check("R9 status bit", {32'd0, v}, 64'd1);
    wr(A_STATUS, 32'd0);
    check("R9 write0 ignored", {63'd0, ovfFlag}, 64'd1);
    wr(A_STATUS, 32'd1);
    check("R9 write1 clears", {63'd0, ovfFlag}, 64'd0);
  endtask

  task automatic t_zero();
    cntZeroReq = 1'b1;
    @(posedge clk); @(negedge clk);
    cntZeroReq = 1'b0;
    check("R10 zero load", timeNow, 64'd0);
    ticks(1);
    check("R10 resume", timeNow, 64'd5);
    wr(A_CFG, CFG_STOP);
    wr(A_HI, 32'd9);
    cntZeroReq = 1'b1;
    wr(A_LO, 32'h1234);
    cntZeroReq = 1'b0;
    check("R10 write wins", timeNow, 64'h9_0000_1234);
  endtask

  initial begin
    #4_000_000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_default();
    t_disabled();
    t_burst();
    t_slow();
    t_latch();
    t_overflow();
    t_zero();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule